// File: doc/BRIEF.md
# Word-Interleaving Four-Port Message Switch

The block links four bidirectional word streams of the kind that sit behind small processor FIFOs. Each input offers a 32-bit word with one control bit, a has-data flag, and gets a read strobe back. Each output gets a 32-bit word, a control bit and a write strobe, and reports a full flag. Traffic is framed: an opening word carries the route, body words follow, and a closing word ends the frame. The switch carries each frame from its input to the output named in the opening word, or to all other outputs for a broadcast.

Arbitration works word by word, not frame by frame. In each clock cycle one input is granted. Its head word is read and, one cycle later, written to the outputs it targets. The grant then rotates, so frames bound for different outputs share the switch one word at a time. An output stays reserved for one frame from its opening word to its closing word. An input that cannot move this cycle is passed over in the same cycle. Broadcast frames win over plain frames.

Top module: `msg_xbar`

## Requirements
- R1: A word with control bit 1 and data bit 0 set is an opening word when its input has no frame in progress. A word with control bit 1 and data bit 0 clear ends the frame in progress. Words with control bit 0 are body words. Data and control are delivered unchanged.
- R2: The target port number (0 to 3) is read from data bits 2:1 of the opening word; data bits 4:3 are ignored. A plain frame is written to that output only.
- R3: When data bits 12:9 of the opening word equal 2, the frame is a broadcast. Every word of it is written to all outputs except the one sharing the source's port number.
- R4: At most one input is read per cycle. The candidates are searched in rotating order, starting at the port after the last one granted, and port 0 is searched first after reset.
- R5: An input that has no data, or whose target outputs are reserved by another frame or are unable to accept a word, is passed over in the same cycle in favour of the next eligible input.
- R6: If any eligible input carries a broadcast frame (its opening word or a later word), only broadcast inputs are granted in that cycle.
- R7: An output reserved by an opening word receives only that frame's words until the closing word has been written; frames therefore never mix at one output.
- R8: A word read in cycle t is written to its outputs in cycle t+1.
- R9: A word is written to an output only if that output's full flag was low, and the output was not being written, in the cycle the word was read. Otherwise the word stays at its input unread.
- R10: A non-opening word at an input with no frame in progress is read and discarded; no output is written.
- R11: Reset is synchronous. While it is held, no input is read and no output is written, and it releases all output reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 4x32 | Head word of each input stream |
| in_ctrl | input | 4 | Control bit of each head word |
| in_valid | input | 4 | Input stream holds a word |
| in_read | output | 4 | Pops the head word of the granted input |
| out_data | output | 4x32 | Word written to each output stream |
| out_ctrl | output | 4 | Control bit of the written word |
| out_write | output | 4 | Write strobe per output |
| out_full | input | 4 | Output stream cannot accept a word |

## Verification
A stale or missing reservation appears at an output as words from two sources mixed inside one frame. It becomes visible on the first write after the competing opening word is read, two cycles at most. A wrong rotation pointer changes the order of the read strobes from the very next grant, and that order is compared against a computed schedule. A lost full-flag check shows up as a write in the cycle after the flag was high.

// File: rtl/msg_xbar.sv
module msg_xbar #(
  parameter int NP = 4,
  parameter int DW = 32,
  parameter logic [3:0] BCAST_CMD = 4'd2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0][DW-1:0]  in_data,
  input  logic [NP-1:0]          in_ctrl,
  input  logic [NP-1:0]          in_valid,
  output logic [NP-1:0]          in_read,
  output logic [NP-1:0][DW-1:0]  out_data,
  output logic [NP-1:0]          out_ctrl,
  output logic [NP-1:0]          out_write,
  input  logic [NP-1:0]          out_full
);
  localparam int PW = $clog2(NP);
  localparam logic [NP-1:0] ONE = 1;

  logic [NP-1:0]         act, tbc, locked, busy, is_hdr, is_tail, ok, wants_bc, pool;
  logic [NP-1:0][NP-1:0] tmask, mask, own;
  logic [PW-1:0]         ptr, gnt;
  logic                  gnt_v;

  assign busy = out_full | out_write;

  always_comb begin
    locked = '0;
    for (int i = 0; i < NP; i++)
      if (act[i]) locked = locked | tmask[i];
  end

  for (genvar i = 0; i < NP; i++) begin : g_port
    logic bc_i;
    assign is_hdr[i]  = in_ctrl[i] & in_data[i][0];
    assign is_tail[i] = in_ctrl[i] & ~in_data[i][0];
    assign bc_i       = in_data[i][12:9] == BCAST_CMD;
    always_comb begin
      if (act[i])       mask[i] = tmask[i];
      else if (!is_hdr[i]) mask[i] = '0;
      else if (bc_i)    mask[i] = ~(ONE << i);
      else              mask[i] = ONE << in_data[i][PW:1];
    end
    assign ok[i] = in_valid[i] & ~|(mask[i] & busy) & (act[i] | ~|(mask[i] & locked));
    assign wants_bc[i] = act[i] ? tbc[i] : (is_hdr[i] & bc_i);
    for (genvar o = 0; o < NP; o++) begin : g_own
      assign own[o][i] = act[i] & tmask[i][o];
    end
  end

  assign pool = |(ok & wants_bc) ? (ok & wants_bc) : ok;

  always_comb begin
    logic [PW-1:0] idx;
    gnt_v = 1'b0;
    gnt   = ptr;
    for (int k = 0; k < NP; k++) begin
      idx = ptr + PW'(k);
      if (!gnt_v && pool[idx]) begin
        gnt_v = 1'b1;
        gnt   = idx;
      end
    end
  end

  assign in_read = (gnt_v && !rst) ? (ONE << gnt) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= '0;
      tbc       <= '0;
      tmask     <= '0;
      ptr       <= '0;
      out_write <= '0;
      out_data  <= '0;
      out_ctrl  <= '0;
    end else begin
      out_write <= '0;
      if (gnt_v) begin
        ptr       <= PW'(gnt + 1'b1);
        out_write <= mask[gnt];
        for (int o = 0; o < NP; o++)
          if (mask[gnt][o]) begin
            out_data[o] <= in_data[gnt];
            out_ctrl[o] <= in_ctrl[gnt];
          end
        if (act[gnt]) begin
          if (is_tail[gnt]) act[gnt] <= 1'b0;
        end else if (is_hdr[gnt]) begin
          act[gnt]   <= 1'b1;
          tmask[gnt] <= mask[gnt];
          tbc[gnt]   <= wants_bc[gnt];
        end
      end
    end
  end

  // R4: one read per cycle
  a_r4_single_read: assert property (@(posedge clk) disable iff (rst) $onehot0(in_read));
  // R8: every write follows a read one cycle earlier
  a_r8_write_after_read: assert property (@(posedge clk) disable iff (rst)
    |out_write |-> $past(|in_read));
  // R11: nothing moves during reset
  a_r11_quiet_reset: assert property (@(posedge clk) rst |-> in_read == '0);
  a_r11_no_write_after_reset: assert property (@(posedge clk) rst |=> out_write == '0);

  for (genvar o = 0; o < NP; o++) begin : g_chk
    // R9: a write needs room when its word was read
    a_r9_room: assert property (@(posedge clk) disable iff (rst)
      out_write[o] |-> ($past(out_full[o]) == 1'b0 && $past(out_write[o]) == 1'b0));
    // R7: one owner per output
    a_r7_single_owner: assert property (@(posedge clk) disable iff (rst) $onehot0(own[o]));
    // R5: a requesting input with data is read only when it has data
    a_r5_read_needs_data: assert property (@(posedge clk) disable iff (rst)
      in_read[o] |-> in_valid[o]);
  end
endmodule

// File: tb/sim_msg_xbar.sv
module sim_msg_xbar;
  logic clk = 0, rst = 1;
  logic [3:0][31:0] in_data, out_data;
  logic [3:0] in_ctrl, in_valid, in_read, out_ctrl, out_write, out_full;

  msg_xbar u0 (.clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl), .in_valid(in_valid),
               .in_read(in_read), .out_data(out_data), .out_ctrl(out_ctrl),
               .out_write(out_write), .out_full(out_full));

  always #10 clk = ~clk;

  logic [32:0] q [4][24];
  logic [32:0] rx[4][40];
  int qn[4], qh[4], rxn[4], first_wr[4];
  int gl[80];
  int gn, cyc, first_rd, total, bad;
  logic [3:0] rd_q;

  task automatic chk(input bit c, input string tag, input longint act, input longint exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int p, input logic [32:0] w);
    q[p][qn[p]] = w;
    qn[p]++;
  endtask

  task automatic msg(input int src, input int dst, input bit bc, input int nbody, input int seed);
    push(src, {1'b1, 32'(seed) << 16 | (bc ? 32'h400 : 32'h200) | 32'(dst) << 1 | 32'h1});
    for (int k = 0; k < nbody; k++) push(src, {1'b0, 32'(seed * 64 + k) << 3 | 32'h5});
    push(src, {1'b1, 32'(seed * 8 + 3) << 1});
  endtask

  function automatic int mism(input int o, input int off, input int src, input int n);
    int m = 0;
    for (int k = 0; k < n; k++) if (rx[o][off + k] !== q[src][k]) m++;
    return m;
  endfunction

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1; out_full = '0;
    for (int i = 0; i < 4; i++) begin qn[i] = 0; qh[i] = 0; end
    @(posedge clk); #2;
    for (int i = 0; i < 4; i++) begin rxn[i] = 0; first_wr[i] = -1; end
    gn = 0; cyc = 0; first_rd = -1; rd_q = '0;
    @(posedge clk); #2;
    rst = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    in_data = '0; in_ctrl = '0; in_valid = '0; out_full = '0; rd_q = '0;
    forever begin
      @(negedge clk);
      for (int o = 0; o < 4; o++)
        if (out_write[o]) begin
          rx[o][rxn[o]] = {out_ctrl[o], out_data[o]};
          rxn[o]++;
          if (first_wr[o] < 0) first_wr[o] = cyc;
        end
      for (int i = 0; i < 4; i++) begin
        if (rd_q[i]) qh[i]++;
        in_valid[i] = qh[i] < qn[i];
        in_data[i]  = in_valid[i] ? q[i][qh[i]][31:0] : '0;
        in_ctrl[i]  = in_valid[i] ? q[i][qh[i]][32] : 1'b0;
      end
      #5;
      rd_q = in_read;
      for (int i = 0; i < 4; i++)
        if (rd_q[i]) begin
          gl[gn] = i; gn++;
          if (first_rd < 0) first_rd = cyc;
        end
      cyc++;
    end
  end

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    do_reset();
    run(2);
    chk(in_read == 0 && out_write == 0, "R11 idle after reset", {in_read, out_write}, 0);

    // R2 R1 R8: every source/target pair
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++) begin
        do_reset();
        msg(s, d, 0, 2, s * 4 + d + 1);
        run(14);
        chk(rxn[d] == 4, "R2 word count at target", rxn[d], 4);
        chk(mism(d, 0, s, 4) == 0, "R1 words unchanged", mism(d, 0, s, 4), 0);
        chk(rxn[0] + rxn[1] + rxn[2] + rxn[3] == 4, "R2 no other output", rxn[0] + rxn[1] + rxn[2] + rxn[3], 4);
        chk(first_wr[d] == first_rd + 1, "R8 one cycle latency", first_wr[d], first_rd + 1);
      end

    // R4: rotating shifts, all inputs busy
    for (int sh = 1; sh < 4; sh++) begin
      int e = 0;
      do_reset();
      for (int i = 0; i < 4; i++) msg(i, (i + sh) % 4, 0, 2, 20 + i);
      run(24);
      chk(gn == 16, "R4 read count", gn, 16);
      for (int k = 0; k < 16; k++) if (gl[k] != k % 4) e++;
      chk(e == 0, "R4 rotation order", e, 0);
      for (int i = 0; i < 4; i++)
        chk(mism((i + sh) % 4, 0, i, 4) == 0 && rxn[(i + sh) % 4] == 4, "R4 interleaved delivery", rxn[(i + sh) % 4], 4);
    end

    // R7: two sources, one target
    do_reset();
    msg(0, 3, 0, 1, 40);
    msg(1, 3, 0, 1, 41);
    run(16);
    chk(rxn[3] == 6, "R7 count", rxn[3], 6);
    chk(mism(3, 0, 0, 3) == 0 && mism(3, 3, 1, 3) == 0, "R7 frames not mixed", mism(3, 0, 0, 3) + mism(3, 3, 1, 3), 0);

    // R3 R6: broadcast beats plain send
    do_reset();
    msg(2, 0, 1, 1, 50);
    msg(0, 1, 0, 1, 51);
    run(18);
    chk(gl[0] == 2, "R6 broadcast first", gl[0], 2);
    chk(rxn[2] == 0, "R3 not to source", rxn[2], 0);
    chk(rxn[0] == 3 && mism(0, 0, 2, 3) == 0, "R3 broadcast at port 0", rxn[0], 3);
    chk(rxn[3] == 3 && mism(3, 0, 2, 3) == 0, "R3 broadcast at port 3", rxn[3], 3);
    chk(rxn[1] == 6 && mism(1, 0, 2, 3) == 0 && mism(1, 3, 0, 3) == 0, "R7 broadcast then send", rxn[1], 6);

    // R9 R5: full output holds its source, others pass
    do_reset();
    out_full = 4'b0010;
    msg(0, 1, 0, 1, 60);
    msg(3, 2, 0, 1, 61);
    run(10);
    chk(rxn[1] == 0, "R9 no write while full", rxn[1], 0);
    chk(qh[0] == 0, "R9 source not read", qh[0], 0);
    chk(rxn[2] == 3 && mism(2, 0, 3, 3) == 0, "R5 other source served", rxn[2], 3);
    out_full = 4'b0000;
    run(10);
    chk(rxn[1] == 3 && mism(1, 0, 0, 3) == 0, "R9 delivered after full clears", rxn[1], 3);

    // R10: stray body word dropped
    do_reset();
    push(1, {1'b0, 32'hABC0});
    msg(1, 0, 0, 1, 70);
    run(12);
    chk(rxn[0] == 3, "R10 stray dropped count", rxn[0], 3);
    chk(mism(0, 0, 1, 0) == 0 && rx[0][0] === q[1][1] && rx[0][2] === q[1][3], "R10 frame intact", rx[0][0], q[1][1]);
    chk(rxn[1] + rxn[2] + rxn[3] == 0, "R10 nothing else written", rxn[1] + rxn[2] + rxn[3], 0);

    // R11 R4: pointer back at port 0, reservations cleared
    do_reset();
    msg(3, 2, 0, 1, 80);
    msg(1, 0, 0, 1, 81);
    run(2);
    chk(gl[0] == 1, "R11 pointer restarts at port 0", gl[0], 1);
    run(1);
    do_reset();
    msg(2, 0, 0, 1, 82);
    run(8);
    chk(rxn[0] == 3 && mism(0, 0, 2, 3) == 0, "R11 reservation released", rxn[0], 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule